// File: doc/BRIEF.md
# Four-Operation 16-bit Arithmetic Datapath

This block is a purely combinational arithmetic stage. It takes two 16-bit operands and a 2-bit operation code, and it returns a 16-bit result and a carry flag. The four operations are:

- an unsigned 8x8 multiply of the operands' low bytes;
- a 16-bit add;
- a 16-bit subtract;
- an increment of the first operand.

One ripple adder serves the add, subtract and increment operations. Operand conditioning in front of the adder lets it do all three. A separate shift-and-add array produces the product.

The carry flag follows a rule set by the operation. It is bit 16 of the sum for add and increment, and it means "no borrow" for subtract. It is always clear during a multiply, because the product already fills the 16-bit result.

The stage has no clock and no state. It is meant to sit between operand registers and a result multiplexer, inside a larger execution unit.

Top module: `arith_unit`

## Requirements
- R1: With op_i = 2'b00, result_o equals the unsigned product of a_i[7:0] and b_i[7:0] as a full 16-bit value.
- R2: With op_i = 2'b00, carry_o is 0 for every operand value, including 0xFF times 0xFF.
- R3: With op_i = 2'b00, the values of a_i[15:8] and b_i[15:8] have no effect on result_o or carry_o.
- R4: With op_i = 2'b01, {carry_o, result_o} equals the 17-bit sum a_i + b_i, so 0x8000 + 0x8000 gives result 0x0000 with carry 1.
- R5: With op_i = 2'b10, result_o equals (a_i - b_i) mod 2^16, and carry_o is 1 exactly when a_i >= b_i (no borrow), so 0 - 1 gives 0xFFFF with carry 0.
- R6: With op_i = 2'b11, {carry_o, result_o} equals a_i + 1. An a_i of 0xFFFF gives 0x0000 with carry 1, and b_i has no effect.
- R7: Outputs depend only on the present inputs. A change on any input is reflected on the outputs in the same cycle, without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand; low byte feeds the multiplier |
| b_i | input | 16 | Second operand; low byte feeds the multiplier |
| op_i | input | 2 | Operation code: 00 multiply, 01 add, 10 subtract, 11 increment |
| result_o | output | 16 | Operation result |
| carry_o | output | 1 | Operation-dependent carry flag |

## Verification
The four operations are each driven with random operand pairs from a fixed seed. Each result is compared with a bench model that computes subtraction by comparison rather than by an inverted add, so a wrong carry polarity or a missing carry-in shows up directly.

Directed cases target the carry boundaries. Add overflow at 0x8000 + 0x8000 separates carry from sign overflow. 0 - 1 and equal operands separate borrow from no-borrow. Incrementing 0xFFFF checks the wrap.

For the multiply, 0xFF times 0xFF checks the largest product. Operands with busy upper bytes show that only the low bytes reach the array. Swapping b_i under increment shows that the second operand is unused there.

// File: rtl/arith_unit_pkg.sv
package arith_unit_pkg;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_INC = 2'b11
  } arith_op_e;

endpackage

// File: rtl/arith_opnd_prep.sv
// Conditions operand B and the carry-in so that a single adder
// serves add, subtract and increment.
module arith_opnd_prep
  import arith_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  arith_op_e         op_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_adj_o,
  output logic              cin_o
);

  always_comb begin
    unique case (op_i)
      OP_ADD: begin
        b_adj_o = b_i;
        cin_o   = 1'b0;
      end
      OP_SUB: begin
        b_adj_o = ~b_i;
        cin_o   = 1'b1;
      end
      OP_INC: begin
        b_adj_o = '0;
        cin_o   = 1'b1;
      end
      default: begin
        b_adj_o = '0;
        cin_o   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/arith_ripple_add.sv
module arith_ripple_add #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);

  logic [DATA_W:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i + 1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = carry[DATA_W];

endmodule

// File: rtl/arith_mul_array.sv
// Unsigned shift-and-add array multiplier.
module arith_mul_array #(
  parameter int unsigned MUL_W = 8,
  localparam int unsigned PROD_W = 2 * MUL_W
) (
  input  logic [MUL_W-1:0]  a_i,
  input  logic [MUL_W-1:0]  b_i,
  output logic [PROD_W-1:0] prod_o
);

  logic [PROD_W-1:0] acc [MUL_W+1];

  assign acc[0] = '0;

  for (genvar r = 0; r < MUL_W; r++) begin : g_row
    logic [PROD_W-1:0] pp;
    assign pp         = PROD_W'({MUL_W{b_i[r]}} & a_i) << r;
    assign acc[r + 1] = acc[r] + pp;
  end

  assign prod_o = acc[MUL_W];

endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MUL_W  = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);

  localparam int unsigned PROD_W = 2 * MUL_W;

  arith_op_e         op;
  logic [DATA_W-1:0] b_adj;
  logic              cin;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic [PROD_W-1:0] prod;

  assign op = arith_op_e'(op_i);

  arith_opnd_prep #(.DATA_W(DATA_W)) i_prep (
    .op_i   (op),
    .b_i    (b_i),
    .b_adj_o(b_adj),
    .cin_o  (cin)
  );

  arith_ripple_add #(.DATA_W(DATA_W)) i_add (
    .a_i   (a_i),
    .b_i   (b_adj),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  arith_mul_array #(.MUL_W(MUL_W)) i_mul (
    .a_i   (a_i[MUL_W-1:0]),
    .b_i   (b_i[MUL_W-1:0]),
    .prod_o(prod)
  );

  always_comb begin
    if (op == OP_MUL) begin
      result_o = DATA_W'(prod);
      carry_o  = 1'b0;
    end else begin
      result_o = sum;
      carry_o  = cout;
    end
  end

endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MUL_W  = 8
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);

  logic [DATA_W:0] ext_a, ext_b, full;
  logic [DATA_W-1:0] lo_prod;

  assign ext_a   = {1'b0, a_i};
  assign ext_b   = {1'b0, b_i};
  assign full    = {carry_o, result_o};
  assign lo_prod = DATA_W'(a_i[MUL_W-1:0]) * DATA_W'(b_i[MUL_W-1:0]);

  always_comb begin
    if (op_i == 2'b00) begin
      a_r1_mul_product: assert (result_o == lo_prod)
        else $error("a_r1_mul_product");
      a_r2_mul_no_carry: assert (!carry_o)
        else $error("a_r2_mul_no_carry");
    end
    if (op_i == 2'b01) begin
      a_r4_add_sum: assert (full == ext_a + ext_b)
        else $error("a_r4_add_sum");
    end
    if (op_i == 2'b10) begin
      a_r5_sub_borrow: assert (carry_o == (a_i >= b_i) && result_o == DATA_W'(a_i - b_i))
        else $error("a_r5_sub_borrow");
    end
    if (op_i == 2'b11) begin
      a_r6_inc: assert (full == ext_a + 1'b1)
        else $error("a_r6_inc");
      a_r6_inc_wrap: assert (!(&a_i) || (result_o == '0 && carry_o))
        else $error("a_r6_inc_wrap");
    end
  end

endmodule

bind arith_unit arith_unit_chk #(.DATA_W(DATA_W), .MUL_W(MUL_W)) i_arith_unit_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .result_o(result_o),
  .carry_o (carry_o)
);

// File: tb/test_arith_unit.sv
module test_arith_unit;

  logic        clk = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [1:0]  op_i = 2'b00;
  logic [15:0] result_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  arith_unit i_arith_unit (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_i),
    .result_o(result_o),
    .carry_o (carry_o)
  );

  function automatic logic [16:0] model(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [16:0] r;
    case (op)
      2'b00:   r = {1'b0, 16'(a[7:0] * b[7:0])};
      2'b01:   r = 17'(a) + 17'(b);
      2'b10:   r = {a >= b, 16'(a - b)};
      default: r = 17'(a) + 17'd1;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp_r, input logic exp_c);
    checks++;
    if (result_o !== exp_r || carry_o !== exp_c) begin
      errors++;
      $display("FAIL %s: op=%b a=%h b=%h got r=%h c=%b exp r=%h c=%b",
               req, op_i, a_i, b_i, result_o, carry_o, exp_r, exp_c);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [16:0] e;
    @(posedge clk);
    op_i = op;
    a_i  = a;
    b_i  = b;
    @(negedge clk);
    e = model(op, a, b);
    check(req, e[15:0], e[16]);
  endtask

  initial begin
    void'($urandom(32'h5eed_0417));
    @(negedge clk);
    check("R1 idle zero", 16'h0000, 1'b0);

    apply("R1 mul max", 2'b00, 16'h00FF, 16'h00FF);
    check("R2 mul max", 16'hFE01, 1'b0);
    apply("R3 mul upper ignored", 2'b00, 16'hA503, 16'h5A07);
    check("R3 mul upper ignored", 16'h0015, 1'b0);
    apply("R3 mul upper only", 2'b00, 16'hFF00, 16'hFF00);
    check("R3 mul upper only", 16'h0000, 1'b0);
    apply("R4 add sign overflow", 2'b01, 16'h8000, 16'h8000);
    check("R4 add sign overflow", 16'h0000, 1'b1);
    apply("R4 add max", 2'b01, 16'hFFFF, 16'hFFFF);
    check("R4 add max", 16'hFFFE, 1'b1);
    apply("R5 sub 0-1", 2'b10, 16'h0000, 16'h0001);
    check("R5 sub 0-1", 16'hFFFF, 1'b0);
    apply("R5 sub equal", 2'b10, 16'h1234, 16'h1234);
    check("R5 sub equal", 16'h0000, 1'b1);
    apply("R6 inc wrap", 2'b11, 16'hFFFF, 16'h0000);
    check("R6 inc wrap", 16'h0000, 1'b1);
    apply("R6 inc b ignored", 2'b11, 16'h7FFF, 16'hFFFF);
    check("R6 inc b ignored", 16'h8000, 1'b0);

    // R7: change inputs mid-cycle, no clock edge between drive and sample
    @(negedge clk);
    op_i = 2'b01; a_i = 16'h0F0F; b_i = 16'h00F1;
    #1 check("R7 comb response", 16'h1000, 1'b0);
    op_i = 2'b10;
    #1 check("R7 comb response", 16'h0E1E, 1'b1);

    for (int op = 0; op < 4; op++) begin
      for (int n = 0; n < 400; n++) begin
        case (op)
          0: apply("R1 mul random", 2'(op), 16'($urandom), 16'($urandom));
          1: apply("R4 add random", 2'(op), 16'($urandom), 16'($urandom));
          2: apply("R5 sub random", 2'(op), 16'($urandom), 16'($urandom));
          default: apply("R6 inc random", 2'(op), 16'($urandom), 16'($urandom));
        endcase
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule